// File: doc/BRIEF.md
# Prescaled Glitch Filter Bank

This block cleans up a set of slow, noisy, asynchronous level inputs (typically external interrupt lines) before they reach edge detection logic. Each channel first brings its raw input into the clock domain through a two-flop synchroniser. It then passes a level change to its filtered output only after the synchronised level has differed from the output for a programmed number of filter ticks. A short pulse leaves the output untouched.

All channels count the same filter tick. A single programmable down-counting divider derives this tick from the block clock, nominally 16 MHz (62.5 ns). Because the channels share the tick and the input is synchronised first, the real filter time equals the programmed count times the tick period, plus an offset of a few ticks. A narrow write port sets the divider reload value and the limit of each channel.

Top module: `glitch_filter_bank`

## Requirements
- R1: After reset all filtered outputs are 0, every channel limit is 0 and the divider reload value is 0, so a filter tick is issued on every clock.
- R2: Each raw input passes through two synchronising flops. With a limit of 0 and a reload value of 0, a level change that is applied between two clock edges appears at the output on the third edge that follows.
- R3: A filtered output changes only to the level its synchronised input had on the previous cycle. It changes on the (M+1)-th tick at or after the third edge following the input change, where M is the channel limit.
- R4: While the synchronised input equals the filtered output, the channel counter is held at 0 and the output does not change. A raw pulse that is shorter than M+1 ticks (at reload 0: M+1 cycles) leaves the output unchanged, and a pulse of exactly M+1 cycles passes.
- R5: With reload value P the divider issues a one-cycle tick every P+1 clocks. A write to the reload value loads the divider at once, so the next tick comes P+1 edges after the write edge.
- R6: Write address map: an address c in 0..24 loads wr_data[3:0] as the limit of channel c. Address 25 loads wr_data[7:0] as the divider reload value. Addresses 26..31 change nothing.
- R7: The channels are independent. Each one times its own input against its own limit, and all of them share the tick.
- R8: A filtered output changes only on a clock edge at which a tick is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, nominally 16 MHz |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Write address: channel limit 0..24, divider reload 25 |
| wr_data | input | 8 | Write data |
| raw_in | input | 25 | Raw asynchronous level inputs |
| filt_o | output | 25 | Filtered levels |

## Verification
An output change is due on a computable edge. The bench takes the edge of the last divider write, W, and the edge after which the input moved, A. It finds the first tick W+k(P+1) that is not earlier than A+3 and adds M(P+1); at reload 0 this reduces to A+3+M. The bench samples every falling edge after a stimulus and records the first edge on which each output shows the new level. That edge must equal the computed one exactly. Glitch checks sample on the edge just before the computed one and on that edge itself. A rejected pulse is judged fifteen or more cycles after the pulse ends.

// File: rtl/glitch_filter_bank.sv
module glitch_filter_bank #(
  parameter int NCH = 25,
  parameter int CW  = 4,
  parameter int PW  = 8,
  parameter int AW  = $clog2(NCH + 1),
  parameter int DW  = (PW > CW) ? PW : CW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [DW-1:0]  wr_data,
  input  logic [NCH-1:0] raw_in,
  output logic [NCH-1:0] filt_o
);

  localparam logic [AW-1:0] DIV_ADDR = AW'(NCH);

  logic [PW-1:0]  presc_q, pdiv_q;
  logic [NCH-1:0] sync1, sync2, filt_q;
  logic           tick, pre_wr;

  assign pre_wr = wr_en && (wr_addr == DIV_ADDR);
  assign tick   = (pdiv_q == '0);
  assign filt_o = filt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc_q <= '0;
      pdiv_q  <= '0;
    end else if (pre_wr) begin
      presc_q <= wr_data[PW-1:0];
      pdiv_q  <= wr_data[PW-1:0];
    end else if (tick) begin
      pdiv_q  <= presc_q;
    end else begin
      pdiv_q  <= pdiv_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= raw_in;
      sync2 <= sync1;
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [CW-1:0] lim_q, cnt_q;
    logic          out_q, ch_wr;

    assign ch_wr     = wr_en && (wr_addr == AW'(i));
    assign filt_q[i] = out_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     lim_q <= '0;
      else if (ch_wr) lim_q <= wr_data[CW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q <= '0;
        out_q <= 1'b0;
      end else if (sync2[i] == out_q) begin
        cnt_q <= '0;
      end else if (tick) begin
        if (cnt_q == lim_q) begin
          out_q <= sync2[i];
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

endmodule

module gfb_checker #(
  parameter int NCH = 25,
  parameter int PW  = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           tick,
  input logic           pre_wr,
  input logic [PW-1:0]  presc,
  input logic [NCH-1:0] sync_in,
  input logic [NCH-1:0] filt_out
);

  AST_MOVE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_out != $past(filt_out)) |-> $past(tick)); // R8

  AST_MOVE_TO_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    ((filt_out ^ $past(filt_out)) & (filt_out ^ $past(sync_in))) == '0); // R3

  AST_HOLD_WHEN_MATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_in == filt_out) |=> (filt_out == $past(filt_out))); // R4

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && presc != '0 && !pre_wr) |=> !tick); // R5

  AST_TICK_EVERY_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (presc == '0 && !pre_wr) |=> tick); // R1

endmodule

bind glitch_filter_bank gfb_checker #(.NCH(NCH), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .pre_wr(pre_wr),
  .presc(presc_q), .sync_in(sync2), .filt_out(filt_q)
);

// File: tb/tb_glitch_filter_bank.sv
module tb_glitch_filter_bank;
  localparam int NCH = 25;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           wr_en = 1'b0;
  logic [4:0]     wr_addr = '0;
  logic [7:0]     wr_data = '0;
  logic [NCH-1:0] raw_in = '0;
  logic [NCH-1:0] filt_o;

  int cyc = 0;
  int errors = 0;
  int checks = 0;
  int last_wr = 0;
  int cur_p = 0;
  int mcfg[NCH];

  glitch_filter_bank dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .raw_in(raw_in), .filt_o(filt_o)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 5'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
    if (a == NCH) begin
      last_wr = cyc;
      cur_p = d;
    end else if (a < NCH) begin
      mcfg[a] = d & 15;
    end
  endtask

  function automatic int first_tick(input int w, input int p, input int t);
    if (t <= w) return w + p + 1;
    return w + ((t - w + p) / (p + 1)) * (p + 1);
  endfunction

  task automatic sweep(input logic lvl, input string req);
    int a;
    int first[NCH];
    @(negedge clk);
    raw_in = {NCH{lvl}};
    a = cyc;
    for (int c = 0; c < NCH; c++) first[c] = -1;
    for (int n = 0; n < 16 * (cur_p + 1) + 8; n++) begin
      @(negedge clk);
      for (int c = 0; c < NCH; c++)
        if (first[c] < 0 && filt_o[c] == lvl) first[c] = cyc;
    end
    for (int c = 0; c < NCH; c++) begin
      int exp;
      exp = first_tick(last_wr, cur_p, a + 3) + mcfg[c] * (cur_p + 1);
      check(first[c] == exp, req, first[c], exp);
    end
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int c = 0; c < NCH; c++) mcfg[c] = 0;
    #1;
    check(filt_o == '0, "R1 outputs in reset", int'(filt_o), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(filt_o == '0, "R1 outputs after reset", int'(filt_o), 0);

    // R2 / R1: default limit 0, default reload 0 -> third edge
    last_wr = 0; cur_p = 0;
    sweep(1'b1, "R2 default latency rise");
    sweep(1'b0, "R2 default latency fall");

    // R3 R5 R7: per-channel limits over several reload values
    for (int p = 0; p < 4; p++) begin
      for (int c = 0; c < NCH; c++) wr(c, (c + 3 * p) % 16);
      wr(NCH, p);
      repeat (p) @(negedge clk);
      sweep(1'b1, "R3 R7 rise latency");
      wr(NCH, p);
      sweep(1'b0, "R5 restart fall latency");
    end

    // R6: upper byte lands in reload value, upper nibble ignored by limits
    for (int c = 0; c < NCH; c++) wr(c, 8'hF2);
    wr(NCH, 8'h00);
    for (int a = NCH + 1; a < 32; a++) wr(a, 8'h0F);
    sweep(1'b1, "R6 ignored addresses rise");
    sweep(1'b0, "R6 ignored addresses fall");
    wr(NCH, 8'h11);
    sweep(1'b1, "R6 full reload width");
    wr(NCH, 0);
    sweep(1'b0, "R6 reload back to zero");

    // R4: glitch rejection with limit 5 at reload 0
    for (int c = 0; c < NCH; c++) wr(c, 5);
    repeat (4) @(negedge clk);
    raw_in = '1;
    repeat (5) @(negedge clk);
    raw_in = '0;
    repeat (15) @(negedge clk);
    check(filt_o == '0, "R4 short pulse rejected", int'(filt_o), 0);
    raw_in = '1;
    begin
      int a;
      a = cyc;
      repeat (6) @(negedge clk);
      raw_in = '0;
      while (cyc < a + 7) @(negedge clk);
      check(filt_o == '0, "R4 exact pulse before due edge", int'(filt_o), 0);
      @(negedge clk);
      check(filt_o == '1, "R4 exact pulse passes", int'(filt_o), int'({NCH{1'b1}}));
    end
    repeat (20) @(negedge clk);
    check(filt_o == '0, "R4 returns low", int'(filt_o), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule